// File: doc/BRIEF.md
# HDLC Frame Buffer Register Interface

This block sits between a CPU bus and the byte-wide transmit and receive handshakes of an HDLC serial framer. It holds one outgoing frame and one incoming frame, each in a buffer of `DEPTH` bytes. Software reaches both buffers through five 8-bit registers at a 3-bit address. Two interrupt lines mirror the "transmission finished" and "frame waiting" status bits, so software can be driven by interrupts or can poll.

To send, software writes the frame bytes one at a time into the transmit data register and then sets the go bit. The framer then pulls the bytes in write order with `tx_take` until the frame is exhausted, and the done bit sets. The framer pushes received bytes with `rx_push` and closes each frame with `rx_end`. A complete frame becomes visible to software together with its length and its error and abort flags. Software can read the frame out, or discard it with one drop command. A frame that does not fit in the buffer, or that arrives while the previous frame is still held, is marked as an overflow and never reaches software.

The block uses one clock. Bus accesses are single-cycle: every cycle in which the strobe is high is one access. It is acknowledged one cycle later, and any read data comes with the acknowledge.

Top module: `hdlc_buf_regs`

## Requirements
- R1: After reset every register reads 0x00, both interrupt lines are low, and `bus_ack`, `tx_frame_valid`, `tx_abort_pulse` and `tx_fcs_en` are low.
- R2: `bus_ack` is high in exactly the cycle after each cycle with `bus_stb` high, and `bus_rdata` carries the read result in that cycle.
- R3: Address 0 reads as transmit status: bit 0 done, bit 3 aborted, bit 4 overflow. Every other bit reads 0, including the write-only go (bit 1), abort (bit 2) and FCS-enable (bit 5) bits.
- R4: Bytes written to address 1 are stored in order. Writing 1 to bit 1 of address 0 while idle starts sending: `tx_frame_valid` is high and `tx_byte` shows the stored bytes in write order, advancing on each cycle with `tx_take` high. The cycle after the last byte is taken, `tx_frame_valid` is low and done and `irq_tx_done` are 1. Starting with an empty buffer sets done at once.
- R5: Data writes to address 1 while a frame is being sent are ignored. They change neither the stored bytes nor the frame length.
- R6: The first data write after done is set clears done, aborted and overflow.
- R7: A data write when `DEPTH` bytes are already stored is dropped and sets the transmit overflow bit (bit 4).
- R8: Writing 1 to bit 2 of address 0 while sending ends the frame at once. `tx_frame_valid` falls, `tx_abort_pulse` is high for one cycle, and done and aborted are set. The same write while idle has no effect.
- R9: Bit 5 of each write to address 0 is held on `tx_fcs_en`.
- R10: When `rx_end` closes a frame of 1 to `DEPTH` bytes with no overflow, address 2 bit 0 (ready) and `irq_rx_ready` rise. Address 4 returns the byte count. Bit 2 and bit 3 of address 2 take `rx_end_crc_err` and `rx_end_abort`, and bit 4 clears.
- R11: Reads of address 3 return the frame bytes in arrival order. After the first such read, address 4 returns 0. Ready clears when the last byte has been read.
- R12: Writing 1 to bit 1 of address 2 while a frame is held discards it: ready, the interrupt and the length all read 0, and the next frame is read from its first byte.
- R13: A push beyond `DEPTH` bytes, or a push while a frame is held, sets receive overflow (address 2 bit 4). The affected frame never raises ready, and the flag clears at the next good frame end.
- R14: Writes to read-only addresses (3, 4) and unused addresses (5–7), and reads of any address other than 3, leave all state unchanged. Address 1 and addresses 5–7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | Access strobe, one access per high cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Acknowledge, one cycle after strobe |
| irq_tx_done | output | 1 | Mirrors transmit done |
| irq_rx_ready | output | 1 | Mirrors receive ready |
| tx_byte | output | 8 | Current outgoing byte |
| tx_frame_valid | output | 1 | Outgoing frame in progress |
| tx_take | input | 1 | Framer consumes `tx_byte` |
| tx_abort_pulse | output | 1 | One-cycle request to send an abort pattern |
| tx_fcs_en | output | 1 | Frame check sequence enable to the framer |
| rx_byte | input | 8 | Incoming byte |
| rx_push | input | 1 | `rx_byte` is valid |
| rx_end | input | 1 | Closes the incoming frame |
| rx_end_crc_err | input | 1 | Frame error status, sampled with `rx_end` |
| rx_end_abort | input | 1 | Abort status, sampled with `rx_end` |

## Verification
The bench builds the block with `DEPTH` = 8. With this depth every transmit fill level from one byte to one past full can be swept, and so can every receive frame length from one byte to full. The overflow edges on both sides are reached in a few dozen cycles. The receive sweep also drives all four combinations of the frame-error and abort status through the length loop. Expected bytes, lengths and status words are computed from the frame index and byte position.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
    // register addresses
    localparam logic [2:0] A_TX_CSR  = 3'd0;
    localparam logic [2:0] A_TX_DATA = 3'd1;
    localparam logic [2:0] A_RX_CSR  = 3'd2;
    localparam logic [2:0] A_RX_DATA = 3'd3;
    localparam logic [2:0] A_RX_LEN  = 3'd4;

    // transmit status/control bit positions
    localparam int TXB_DONE    = 0;
    localparam int TXB_GO      = 1;
    localparam int TXB_KILL    = 2;
    localparam int TXB_ABORTED = 3;
    localparam int TXB_OVF     = 4;
    localparam int TXB_FCS     = 5;

    // receive status/control bit positions
    localparam int RXB_READY   = 0;
    localparam int RXB_DROP    = 1;
    localparam int RXB_ERR     = 2;
    localparam int RXB_ABORTED = 3;
    localparam int RXB_OVF     = 4;
endpackage

// File: rtl/hfb_ram.sv
module hfb_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hfb_tx_buf.sv
module hfb_tx_buf
    import hfb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr,
    input  logic [7:0] data_in,
    input  logic       csr_wr,
    input  logic       go_bit,
    input  logic       kill_bit,
    input  logic       fcs_bit,
    input  logic       tx_take,
    output logic [7:0] tx_byte,
    output logic       tx_frame_valid,
    output logic       tx_abort_pulse,
    output logic       tx_fcs_en,
    output logic       done,
    output logic [7:0] csr_rdata
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             aborted;
        logic             ovf;
        logic             fcs;
        logic             kill;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rptr;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic      ram_we;

    always_comb begin
        st_d      = st_q;
        st_d.kill = 1'b0;
        ram_we    = 1'b0;

        // framer consumes bytes of the running frame
        if (st_q.busy && tx_take) begin
            st_d.rptr = st_q.rptr + ONE;
            if (st_q.rptr + ONE == st_q.wcnt) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.wcnt = '0;
                st_d.rptr = '0;
            end
        end

        // control writes: go when idle, abort when busy
        if (csr_wr) begin
            st_d.fcs = fcs_bit;
            if (!st_q.busy && go_bit) begin
                if (st_q.wcnt == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.rptr = '0;
                end
            end
            if (st_q.busy && kill_bit) begin
                st_d.busy    = 1'b0;
                st_d.done    = 1'b1;
                st_d.aborted = 1'b1;
                st_d.kill    = 1'b1;
                st_d.wcnt    = '0;
                st_d.rptr    = '0;
            end
        end

        // data writes are locked out while sending
        if (data_wr && !st_q.busy) begin
            if (st_q.done) begin
                st_d.done    = 1'b0;
                st_d.aborted = 1'b0;
                st_d.ovf     = 1'b0;
            end
            if (st_q.wcnt == FULL) begin
                st_d.ovf = 1'b1;
            end else begin
                ram_we    = 1'b1;
                st_d.wcnt = st_q.wcnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    hfb_ram #(.W(8), .DEPTH(DEPTH), .AW(AW)) i_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (st_q.wcnt[AW-1:0]),
        .wdata (data_in),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (tx_byte)
    );

    always_comb begin
        csr_rdata              = '0;
        csr_rdata[TXB_DONE]    = st_q.done;
        csr_rdata[TXB_ABORTED] = st_q.aborted;
        csr_rdata[TXB_OVF]     = st_q.ovf;
    end

    assign tx_frame_valid = st_q.busy;
    assign tx_abort_pulse = st_q.kill;
    assign tx_fcs_en      = st_q.fcs;
    assign done           = st_q.done;

    // R4: a frame that stops sending always leaves done set
    a_r4_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> st_q.done);

    // R5: the stored length cannot move while a frame is in flight
    a_r5_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.wcnt));

    // R7: fill level and read position stay inside the buffer
    a_r7_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wcnt <= FULL) && (st_q.rptr <= st_q.wcnt));

    // R8: an abort request only appears with the frame closed and flagged
    a_r8_kill_flags: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kill |-> (st_q.done && st_q.aborted && !st_q.busy));
endmodule

// File: rtl/hfb_rx_buf.sv
module hfb_rx_buf
    import hfb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       rx_end,
    input  logic       rx_end_crc_err,
    input  logic       rx_end_abort,
    input  logic       data_rd,
    input  logic       drop_wr,
    output logic [7:0] rd_byte,
    output logic [7:0] csr_rdata,
    output logic [7:0] len_rdata,
    output logic       ready
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic             ready;
        logic             err;
        logic             abt;
        logic             ovf;
        logic             spoil;
        logic             lenv;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rptr;
        logic [CNT_W-1:0] len;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic      ram_we;

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;

        // software side: read out or drop the held frame
        if (data_rd && st_q.ready) begin
            st_d.rptr = st_q.rptr + ONE;
            st_d.lenv = 1'b0;
            if (st_q.rptr + ONE == st_q.len) begin
                st_d.ready = 1'b0;
                st_d.rptr  = '0;
            end
        end
        if (drop_wr && st_q.ready) begin
            st_d.ready = 1'b0;
            st_d.lenv  = 1'b0;
            st_d.rptr  = '0;
        end

        // framer side: collect bytes, spoil the frame on overflow
        if (rx_push) begin
            if (st_q.ready || st_q.spoil || st_q.wcnt == FULL) begin
                st_d.spoil = 1'b1;
                st_d.ovf   = 1'b1;
            end else begin
                ram_we    = 1'b1;
                st_d.wcnt = st_q.wcnt + ONE;
            end
        end
        if (rx_end) begin
            if (st_d.spoil) begin
                st_d.spoil = 1'b0;
                st_d.wcnt  = '0;
                if (!st_q.ready) begin
                    st_d.err = 1'b0;
                    st_d.abt = 1'b0;
                end
            end else if (st_d.wcnt != '0) begin
                st_d.ready = 1'b1;
                st_d.len   = st_d.wcnt;
                st_d.lenv  = 1'b1;
                st_d.err   = rx_end_crc_err;
                st_d.abt   = rx_end_abort;
                st_d.ovf   = 1'b0;
                st_d.wcnt  = '0;
                st_d.rptr  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    hfb_ram #(.W(8), .DEPTH(DEPTH), .AW(AW)) i_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (st_q.wcnt[AW-1:0]),
        .wdata (rx_byte),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (rd_byte)
    );

    always_comb begin
        csr_rdata              = '0;
        csr_rdata[RXB_READY]   = st_q.ready;
        csr_rdata[RXB_ERR]     = st_q.err;
        csr_rdata[RXB_ABORTED] = st_q.abt;
        csr_rdata[RXB_OVF]     = st_q.ovf;
        len_rdata              = st_q.lenv ? 8'(st_q.len) : 8'h00;
    end

    assign ready = st_q.ready;

    // R10: a frame becomes visible only together with a non-zero length
    a_r10_ready_has_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> (st_q.lenv && st_q.len != '0));

    // R11: the read position never leaves the held frame
    a_r11_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready |-> (st_q.rptr < st_q.len));

    // R13: a spoiled frame stores nothing more
    a_r13_spoil_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.spoil && !rx_end) |=> $stable(st_q.wcnt));

    // R13: fill level stays inside the buffer
    a_r13_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wcnt <= FULL);
endmodule

// File: rtl/hdlc_buf_regs.sv
module hdlc_buf_regs
    import hfb_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_stb,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_ack,
    output logic       irq_tx_done,
    output logic       irq_rx_ready,
    output logic [7:0] tx_byte,
    output logic       tx_frame_valid,
    input  logic       tx_take,
    output logic       tx_abort_pulse,
    output logic       tx_fcs_en,
    input  logic [7:0] rx_byte,
    input  logic       rx_push,
    input  logic       rx_end,
    input  logic       rx_end_crc_err,
    input  logic       rx_end_abort
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic       ack;
        logic [7:0] rdata;
    } bus_state_t;

    bus_state_t bs_q, bs_d;

    logic       wr_acc, rd_acc;
    logic       tx_data_wr, tx_csr_wr, rx_csr_wr, rx_data_rd;
    logic [7:0] tx_csr_rd, rx_csr_rd, rx_len_rd, rx_data_byte;

    always_comb begin
        wr_acc     = bus_stb && bus_we;
        rd_acc     = bus_stb && !bus_we;
        tx_data_wr = wr_acc && (bus_addr == A_TX_DATA);
        tx_csr_wr  = wr_acc && (bus_addr == A_TX_CSR);
        rx_csr_wr  = wr_acc && (bus_addr == A_RX_CSR);
        rx_data_rd = rd_acc && (bus_addr == A_RX_DATA);

        bs_d.ack   = bus_stb;
        bs_d.rdata = '0;
        if (rd_acc) begin
            case (bus_addr)
                A_TX_CSR:  bs_d.rdata = tx_csr_rd;
                A_RX_CSR:  bs_d.rdata = rx_csr_rd;
                A_RX_DATA: bs_d.rdata = rx_data_byte;
                A_RX_LEN:  bs_d.rdata = rx_len_rd;
                default:   bs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bs_q <= '0;
        end else begin
            bs_q <= bs_d;
        end
    end

    hfb_tx_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) i_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .data_wr        (tx_data_wr),
        .data_in        (bus_wdata),
        .csr_wr         (tx_csr_wr),
        .go_bit         (bus_wdata[TXB_GO]),
        .kill_bit       (bus_wdata[TXB_KILL]),
        .fcs_bit        (bus_wdata[TXB_FCS]),
        .tx_take        (tx_take),
        .tx_byte        (tx_byte),
        .tx_frame_valid (tx_frame_valid),
        .tx_abort_pulse (tx_abort_pulse),
        .tx_fcs_en      (tx_fcs_en),
        .done           (irq_tx_done),
        .csr_rdata      (tx_csr_rd)
    );

    hfb_rx_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) i_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_push        (rx_push),
        .rx_byte        (rx_byte),
        .rx_end         (rx_end),
        .rx_end_crc_err (rx_end_crc_err),
        .rx_end_abort   (rx_end_abort),
        .data_rd        (rx_data_rd),
        .drop_wr        (rx_csr_wr && bus_wdata[RXB_DROP]),
        .rd_byte        (rx_data_byte),
        .csr_rdata      (rx_csr_rd),
        .len_rdata      (rx_len_rd),
        .ready          (irq_rx_ready)
    );

    assign bus_ack   = bs_q.ack;
    assign bus_rdata = bs_q.rdata;

    // R2: every strobe is answered in the following cycle
    a_r2_ack_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |=> bus_ack);

    // R2: no acknowledge without a strobe the cycle before
    a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stb |=> !bus_ack);

    // R14: a write access returns no data
    a_r14_write_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_we) |=> (bus_rdata == 8'h00));
endmodule

// File: tb/test_hdlc_buf_regs.sv
module test_hdlc_buf_regs;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_stb = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ack, irq_tx_done, irq_rx_ready;
    logic [7:0] tx_byte;
    logic       tx_frame_valid, tx_abort_pulse, tx_fcs_en;
    logic       tx_take = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_push = 1'b0, rx_end = 1'b0;
    logic       rx_end_crc_err = 1'b0, rx_end_abort = 1'b0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;
    logic [7:0] rd;
    logic       ack_seen;

    always #10 clk = ~clk;

    hdlc_buf_regs #(.DEPTH(DEPTH)) i_hdlc_buf_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .irq_tx_done(irq_tx_done), .irq_rx_ready(irq_rx_ready),
        .tx_byte(tx_byte), .tx_frame_valid(tx_frame_valid), .tx_take(tx_take),
        .tx_abort_pulse(tx_abort_pulse), .tx_fcs_en(tx_fcs_en),
        .rx_byte(rx_byte), .rx_push(rx_push), .rx_end(rx_end),
        .rx_end_crc_err(rx_end_crc_err), .rx_end_abort(rx_end_abort)
    );

    function automatic logic [7:0] tv(input int n, input int i);
        return 8'((n * 37 + i * 5 + 3) % 256);
    endfunction

    function automatic logic [7:0] rv(input int k, input int i);
        return 8'((k * 29 + i * 11 + 7) % 256);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
        ack_seen = bus_ack;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_stb = 1'b0;
        d = bus_rdata;
        ack_seen = bus_ack;
    endtask

    task automatic take_one();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic push_frame(input int n, input int k, input logic err, input logic abt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_push = 1'b1; rx_byte = rv(k, i);
        end
        @(negedge clk);
        rx_push = 1'b0; rx_end = 1'b1; rx_end_crc_err = err; rx_end_abort = abt;
        @(negedge clk);
        rx_end = 1'b0; rx_end_crc_err = 1'b0; rx_end_abort = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 ack", bus_ack, 0);
        chk("R1 irq_tx", irq_tx_done, 0);
        chk("R1 irq_rx", irq_rx_ready, 0);
        chk("R1 valid/pulse/fcs", {tx_frame_valid, tx_abort_pulse, tx_fcs_en}, 0);
        bus_read(3'd0, rd); chk("R1 tx csr", rd, 8'h00);
        chk("R2 ack after read", ack_seen, 1);
        @(negedge clk); chk("R2 ack single", bus_ack, 0);
        bus_read(3'd2, rd); chk("R1 rx csr", rd, 8'h00);
        bus_read(3'd4, rd); chk("R1 rx len", rd, 8'h00);

        // R4/R5/R6/R7: transmit sweep over all fill levels
        for (int n = 1; n <= DEPTH + 1; n++) begin
            int stored;
            stored = (n > DEPTH) ? DEPTH : n;
            for (int i = 0; i < n; i++) begin
                bus_write(3'd1, tv(n, i));
                if (i == 0) begin
                    bus_read(3'd0, rd);
                    chk("R6 first write clears status", rd, 8'h00);
                end
            end
            bus_read(3'd0, rd);
            chk("R7 overflow flag", rd, (n > DEPTH) ? 8'h10 : 8'h00);
            bus_write(3'd0, 8'h02);
            chk("R4 frame valid after go", tx_frame_valid, 1);
            for (int i = 0; i < stored; i++) begin
                chk("R4 byte order", tx_byte, tv(n, i));
                if (i == 0) begin
                    bus_write(3'd1, 8'hEE);
                    chk("R5 byte kept during send", tx_byte, tv(n, 0));
                end
                take_one();
            end
            chk("R4 valid low after last", tx_frame_valid, 0);
            chk("R4 irq done", irq_tx_done, 1);
            bus_read(3'd0, rd);
            chk("R4 done status", rd, (n > DEPTH) ? 8'h11 : 8'h01);
        end

        // R4: go with an empty buffer completes at once
        bus_write(3'd0, 8'h02);
        chk("R4 empty go no valid", tx_frame_valid, 0);
        bus_read(3'd0, rd); chk("R4 empty go status", rd, 8'h11);

        // R8: abort while sending
        for (int i = 0; i < 3; i++) bus_write(3'd1, tv(50, i));
        bus_write(3'd0, 8'h02);
        take_one();
        bus_write(3'd0, 8'h04);
        chk("R8 abort pulse", tx_abort_pulse, 1);
        chk("R8 valid falls", tx_frame_valid, 0);
        @(negedge clk); chk("R8 pulse one cycle", tx_abort_pulse, 0);
        bus_read(3'd0, rd); chk("R8 aborted status", rd, 8'h09);
        bus_write(3'd0, 8'h04);
        chk("R8 idle abort no pulse", tx_abort_pulse, 0);

        // R9 / R3: fcs enable, write-only bits read 0
        bus_write(3'd0, 8'h20);
        chk("R9 fcs on", tx_fcs_en, 1);
        bus_read(3'd0, rd); chk("R3 wo bits read 0", rd, 8'h09);
        bus_write(3'd0, 8'h00);
        chk("R9 fcs off", tx_fcs_en, 0);
        bus_read(3'd1, rd); chk("R14 addr1 reads 0", rd, 8'h00);

        // R10/R11: receive sweep over all lengths and status combinations
        for (int n = 1; n <= DEPTH; n++) begin
            logic e, a;
            int   st;
            e = n[0]; a = n[1];
            st = (int'(a) << 3) | (int'(e) << 2);
            push_frame(n, n, e, a);
            bus_read(3'd2, rd); chk("R10 rx status", rd, st | 1);
            chk("R10 irq rx", irq_rx_ready, 1);
            if (n == DEPTH) begin
                bus_write(3'd3, 8'hFF);
                bus_write(3'd4, 8'hFF);
                bus_write(3'd5, 8'hFF);
                bus_read(3'd6, rd); chk("R14 unused reads 0", rd, 8'h00);
                bus_read(3'd0, rd);
                bus_read(3'd2, rd); chk("R14 status unchanged", rd, st | 1);
            end
            bus_read(3'd4, rd); chk("R10 length", rd, n);
            for (int i = 0; i < n; i++) begin
                bus_read(3'd3, rd); chk("R11 rx byte", rd, rv(n, i));
                if (i == 0) begin
                    bus_read(3'd4, rd); chk("R11 len cleared", rd, 0);
                end
            end
            bus_read(3'd2, rd); chk("R11 ready clears", rd, st);
            chk("R11 irq rx low", irq_rx_ready, 0);
        end

        // R13: overflow by length
        push_frame(DEPTH + 1, 99, 1'b1, 1'b1);
        bus_read(3'd2, rd); chk("R13 overflow status", rd, 8'h10);
        chk("R13 no irq", irq_rx_ready, 0);
        bus_read(3'd4, rd); chk("R13 no length", rd, 0);
        push_frame(2, 50, 1'b0, 1'b0);
        bus_read(3'd2, rd); chk("R13 good frame clears", rd, 8'h01);
        for (int i = 0; i < 2; i++) begin
            bus_read(3'd3, rd); chk("R13 next frame byte", rd, rv(50, i));
        end

        // R13: push while a frame is held
        push_frame(3, 60, 1'b0, 1'b0);
        push_frame(2, 70, 1'b0, 1'b0);
        bus_read(3'd2, rd); chk("R13 held overflow", rd, 8'h11);
        bus_read(3'd4, rd); chk("R13 held length", rd, 3);
        for (int i = 0; i < 3; i++) begin
            bus_read(3'd3, rd); chk("R13 held bytes intact", rd, rv(60, i));
        end
        bus_read(3'd2, rd); chk("R13 after drain", rd, 8'h10);

        // R12: drop
        push_frame(4, 90, 1'b0, 1'b0);
        bus_write(3'd2, 8'h02);
        bus_read(3'd2, rd); chk("R12 drop status", rd, 8'h00);
        chk("R12 drop irq", irq_rx_ready, 0);
        bus_read(3'd4, rd); chk("R12 drop length", rd, 0);
        push_frame(2, 91, 1'b0, 1'b0);
        bus_read(3'd3, rd); chk("R12 next frame first byte", rd, rv(91, 0));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule